// File: doc/BRIEF.md
# Data Cache Request Controller

This block decides, in a single cycle, what a data cache does with one incoming load, store or atomic request. It looks up the set-associative tag state and the table of outstanding misses. It applies the configured store policy: allocate-on-write or write-around, and copy-back or write-through. It then answers HIT, MISS or a reservation failure on the same cycle. Any resulting traffic for lower memory goes into a bounded FIFO: a block fetch, the store itself, or a copy-back of a dirty victim. A request is accepted only when the FIFO and the miss table can take the largest burst that the chosen policy path could produce. A rejected request leaves no trace, and the requester retries it later.

The tag state, the outstanding-miss table and the outgoing FIFO live inside the block. A completion input marks a fetched block as resident and frees its miss-table entry. Data storage and the lower memory are outside the block.

Top module: `dcache_req_ctrl`

## Requirements
- R1: Status codes are HIT=0, MISS=1, REJECT=2. When every way of the addressed set is awaiting a fetch and none holds the requested tag, every request to that set returns REJECT. No handler runs, nothing is queued and no state changes.
- R2: A read that finds its tag resident returns HIT, queues nothing and makes that line most recently used. A new line goes into the first invalid way of the set, or else into the least recently used way that is not awaiting a fetch.
- R3: An atomic read that hits marks the line dirty, so that its later eviction in copy-back mode produces a copy-back entry.
- R4: A read miss is accepted only if mq_count+2 <= MQ_DEPTH, and otherwise returns REJECT. An accepted miss that allocates queues a fetch: kind 0, carrying the block address, which is req_addr with its low log2(LINE_BYTES) bits cleared. A request never carries more than LINE_BYTES bytes.
- R5: If the block already has a miss entry with fewer than MERGE_MAX requests, a read miss merges into it and returns MISS without queueing. If the block has no entry and a free one exists, the miss allocates it. In every other case the read miss returns REJECT.
- R6: A copy-back (kind 2, the victim's block address) is queued just after the fetch, and only when the victim line is dirty and copy-back mode is set.
- R7: A store miss in allocate mode is accepted only if mq_count+3 <= MQ_DEPTH and the miss table can take the block. It then queues the store (kind 1, full address), the fetch, and any copy-back, in that order, and returns MISS.
- R8: A store miss in write-around mode queues only the store and returns MISS, with no line allocated. It is rejected only when mq_count+1 > MQ_DEPTH.
- R9: A store that hits returns HIT. In copy-back mode it marks the line dirty and queues nothing. In write-through mode it queues the store, and needs one free slot to do so.
- R10: The queue is empty after reset. It presents entries in push order and lowers mq_count by one on each mq_pop while it is non-empty.
- R11: A completion for a block makes its pending line resident and frees its miss entry, so later reads of the block hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_alloc_on_write | input | 1 | 1: store misses allocate; 0: write-around |
| cfg_copy_back | input | 1 | 1: copy-back; 0: write-through |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a store |
| req_atomic | input | 1 | Request is an atomic (read type) |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | SZ_W | Access size in bytes |
| resp_status | output | 2 | Same-cycle status of the request |
| mq_valid | output | 1 | Queue head is valid |
| mq_kind | output | 2 | Head kind: 0 fetch, 1 store, 2 copy-back |
| mq_addr | output | ADDR_W | Head address |
| mq_count | output | clog2(MQ_DEPTH+1) | Queue occupancy |
| mq_pop | input | 1 | Remove the head entry |
| cpl_valid | input | 1 | A block fetch has completed |
| cpl_addr | input | ADDR_W | Address of the completed block |

## Verification
The assertions assume three things about the inputs. Requests never exceed one line. The policy inputs change only while reset is held. A completion never arrives in the same cycle as a request to the same set. The directed stimulus keeps to all three. It changes mode only inside a reset, issues completions on their own cycles, and uses accesses no larger than a line. It reaches the rejection paths by filling the queue or the miss table deliberately, rather than by racing pops against pushes.

// File: rtl/dcache_req_ctrl.sv
module dcache_req_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int MSHR_N     = 2,
  parameter int MERGE_MAX  = 2,
  parameter int MQ_DEPTH   = 4,
  parameter int SZ_W       = $clog2(LINE_BYTES) + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_alloc_on_write,
  input  logic                          cfg_copy_back,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_atomic,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [SZ_W-1:0]               req_bytes,
  output logic [1:0]                    resp_status,
  output logic                          mq_valid,
  output logic [1:0]                    mq_kind,
  output logic [ADDR_W-1:0]             mq_addr,
  output logic [$clog2(MQ_DEPTH+1)-1:0] mq_count,
  input  logic                          mq_pop,
  input  logic                          cpl_valid,
  input  logic [ADDR_W-1:0]             cpl_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int MI_W  = (MSHR_N > 1) ? $clog2(MSHR_N) : 1;
  localparam int MC_W  = $clog2(MERGE_MAX + 1);
  localparam int PTR_W = $clog2(MQ_DEPTH);
  localparam int CNT_W = $clog2(MQ_DEPTH + 1);

  localparam logic [1:0] S_HIT = 2'd0, S_MISS = 2'd1, S_REJ = 2'd2;
  localparam logic [1:0] L_INV = 2'd0, L_VAL = 2'd1, L_DIRTY = 2'd2, L_WAIT = 2'd3;
  localparam logic [1:0] K_FETCH = 2'd0, K_STORE = 2'd1, K_CPYBK = 2'd2;

  logic [1:0]        ln_st  [SETS][WAYS];
  logic [TAG_W-1:0]  ln_tag [SETS][WAYS];
  logic [WAY_W-1:0]  ln_age [SETS][WAYS];
  logic              ms_v   [MSHR_N];
  logic [BLK_W-1:0]  ms_blk [MSHR_N];
  logic [MC_W-1:0]   ms_cnt [MSHR_N];
  logic [1:0]        q_kind [MQ_DEPTH];
  logic [ADDR_W-1:0] q_addr [MQ_DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  q_cnt;

  logic [BLK_W-1:0] blk, cblk;
  logic [SET_W-1:0] set_i, cset;
  logic [TAG_W-1:0] tag_i, ctag;
  assign blk   = req_addr[ADDR_W-1:OFF_W];
  assign set_i = blk[SET_W-1:0];
  assign tag_i = blk[BLK_W-1:SET_W];
  assign cblk  = cpl_addr[ADDR_W-1:OFF_W];
  assign cset  = cblk[SET_W-1:0];
  assign ctag  = cblk[BLK_W-1:SET_W];

  logic             hit, pend, vic_ok;
  logic [WAY_W-1:0] hw, vw;
  logic [1:0]       probe;

  always_comb begin
    logic             have_inv, have_old;
    logic [WAY_W-1:0] inv_w, old_w, best;
    hit = 1'b0; pend = 1'b0; hw = '0;
    have_inv = 1'b0; inv_w = '0; have_old = 1'b0; old_w = '0; best = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ln_tag[set_i][w] == tag_i && (ln_st[set_i][w] == L_VAL || ln_st[set_i][w] == L_DIRTY)) begin
        hit = 1'b1; hw = WAY_W'(w);
      end
      if (ln_tag[set_i][w] == tag_i && ln_st[set_i][w] == L_WAIT) pend = 1'b1;
      if (ln_st[set_i][w] == L_INV && !have_inv) begin
        have_inv = 1'b1; inv_w = WAY_W'(w);
      end
      if ((ln_st[set_i][w] == L_VAL || ln_st[set_i][w] == L_DIRTY) &&
          (!have_old || ln_age[set_i][w] > best)) begin
        have_old = 1'b1; old_w = WAY_W'(w); best = ln_age[set_i][w];
      end
    end
    vic_ok = have_inv || have_old;
    vw     = have_inv ? inv_w : old_w;
    probe  = hit ? S_HIT : ((pend || vic_ok) ? S_MISS : S_REJ);
  end

  logic            m_hit, m_free, m_avail;
  logic [MI_W-1:0] mh, mf;
  always_comb begin
    m_hit = 1'b0; mh = '0; m_free = 1'b0; mf = '0;
    for (int m = 0; m < MSHR_N; m++) begin
      if (ms_v[m] && ms_blk[m] == blk) begin m_hit = 1'b1; mh = MI_W'(m); end
      if (!ms_v[m] && !m_free) begin m_free = 1'b1; mf = MI_W'(m); end
    end
  end
  assign m_avail = m_hit ? (int'(ms_cnt[mh]) < MERGE_MAX) : m_free;

  logic room1, room2, room3;
  assign room1 = int'(q_cnt) + 1 <= MQ_DEPTH;
  assign room2 = int'(q_cnt) + 2 <= MQ_DEPTH;
  assign room3 = int'(q_cnt) + 3 <= MQ_DEPTH;

  logic              touch, set_dirty, wr_first, rd_go, m_new, m_add;
  logic [1:0]        p_n;
  logic [1:0]        p_kind [3];
  logic [ADDR_W-1:0] p_addr [3];
  logic [WAY_W-1:0]  tw;

  always_comb begin
    int n;
    resp_status = S_REJ;
    touch = 1'b0; set_dirty = 1'b0; wr_first = 1'b0; rd_go = 1'b0;
    if (req_valid && probe != S_REJ) begin
      if (req_write) begin
        if (probe == S_HIT) begin
          if (cfg_copy_back) begin
            touch = 1'b1; set_dirty = 1'b1; resp_status = S_HIT;
          end else if (room1) begin
            touch = 1'b1; wr_first = 1'b1; resp_status = S_HIT;
          end
        end else if (cfg_alloc_on_write) begin
          if (room3 && m_avail && (m_hit || room1) && (m_hit || vic_ok)) begin
            wr_first = 1'b1; rd_go = 1'b1; resp_status = S_MISS;
          end
        end else if (room1) begin
          wr_first = 1'b1; resp_status = S_MISS;
        end
      end else if (probe == S_HIT) begin
        touch = 1'b1; set_dirty = req_atomic; resp_status = S_HIT;
      end else if (room2 && m_avail && (m_hit || vic_ok)) begin
        rd_go = 1'b1; resp_status = S_MISS;
      end
    end
    m_add = rd_go && m_hit;
    m_new = rd_go && !m_hit;
    tw    = m_new ? vw : hw;
    for (int i = 0; i < 3; i++) begin p_kind[i] = K_FETCH; p_addr[i] = '0; end
    n = 0;
    if (wr_first) begin p_kind[0] = K_STORE; p_addr[0] = req_addr; n = 1; end
    if (m_new) begin
      p_kind[n] = K_FETCH; p_addr[n] = {blk, {OFF_W{1'b0}}}; n = n + 1;
      if (ln_st[set_i][vw] == L_DIRTY && cfg_copy_back) begin
        p_kind[n] = K_CPYBK; p_addr[n] = {ln_tag[set_i][vw], set_i, {OFF_W{1'b0}}}; n = n + 1;
      end
    end
    p_n = 2'(n);
  end

  logic pop_ok;
  assign pop_ok = mq_pop && q_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          ln_st[s][w] <= L_INV; ln_tag[s][w] <= '0; ln_age[s][w] <= WAY_W'(w);
        end
      for (int m = 0; m < MSHR_N; m++) begin
        ms_v[m] <= 1'b0; ms_blk[m] <= '0; ms_cnt[m] <= '0;
      end
      for (int i = 0; i < MQ_DEPTH; i++) begin q_kind[i] <= K_FETCH; q_addr[i] <= '0; end
      rd_ptr <= '0; wr_ptr <= '0; q_cnt <= '0;
    end else begin
      if (cpl_valid) begin
        for (int m = 0; m < MSHR_N; m++)
          if (ms_v[m] && ms_blk[m] == cblk) ms_v[m] <= 1'b0;
        for (int w = 0; w < WAYS; w++)
          if (ln_st[cset][w] == L_WAIT && ln_tag[cset][w] == ctag) ln_st[cset][w] <= L_VAL;
      end
      if (touch || m_new) begin
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == tw) ln_age[set_i][w] <= '0;
          else if (ln_age[set_i][w] < ln_age[set_i][tw]) ln_age[set_i][w] <= ln_age[set_i][w] + 1'b1;
      end
      if (set_dirty) ln_st[set_i][hw] <= L_DIRTY;
      if (m_new) begin
        ln_st[set_i][vw]  <= L_WAIT;
        ln_tag[set_i][vw] <= tag_i;
        ms_v[mf] <= 1'b1; ms_blk[mf] <= blk; ms_cnt[mf] <= MC_W'(1);
      end
      if (m_add) ms_cnt[mh] <= ms_cnt[mh] + 1'b1;
      for (int i = 0; i < 3; i++)
        if (i < int'(p_n)) begin
          q_kind[wr_ptr + PTR_W'(i)] <= p_kind[i];
          q_addr[wr_ptr + PTR_W'(i)] <= p_addr[i];
        end
      wr_ptr <= wr_ptr + PTR_W'(p_n);
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
      q_cnt <= q_cnt + CNT_W'(p_n) - CNT_W'(pop_ok);
    end
  end

  assign mq_valid = q_cnt != '0;
  assign mq_kind  = q_kind[rd_ptr];
  assign mq_addr  = q_addr[rd_ptr];
  assign mq_count = q_cnt;

  p_req_fits_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> int'(req_bytes) <= LINE_BYTES);

  p_set_busy_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && !pend && !vic_ok) |-> (resp_status == S_REJ && p_n == 2'd0));

  p_reject_leaves_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_status == S_REJ && !mq_pop) |=> mq_count == $past(mq_count));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mq_count) <= MQ_DEPTH);

  p_no_copyback_in_wt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_copy_back && mq_valid) |-> mq_kind != K_CPYBK);

  p_hit_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_status == S_HIT && (!req_write || cfg_copy_back) && !mq_pop)
    |=> mq_count == $past(mq_count));
endmodule

// File: tb/test_dcache_req_ctrl.sv
`timescale 1ns/1ps
module test_dcache_req_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_alloc_on_write = 1'b1, cfg_copy_back = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_atomic = 1'b0;
  logic [15:0] req_addr = '0;
  logic [5:0]  req_bytes = 6'd4;
  logic [1:0]  resp_status, mq_kind;
  logic        mq_valid, mq_pop = 1'b0, cpl_valid = 1'b0;
  logic [15:0] mq_addr, cpl_addr = '0;
  logic [2:0]  mq_count;
  int checks = 0, errors = 0;

  localparam int HIT = 0, MISS = 1, REJ = 2;
  localparam int FETCH = 0, STORE = 1, CPYBK = 2;

  always #4 clk = ~clk;

  dcache_req_ctrl i_dcache_req_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_alloc_on_write(cfg_alloc_on_write),
    .cfg_copy_back(cfg_copy_back), .req_valid(req_valid), .req_write(req_write),
    .req_atomic(req_atomic), .req_addr(req_addr), .req_bytes(req_bytes),
    .resp_status(resp_status), .mq_valid(mq_valid), .mq_kind(mq_kind),
    .mq_addr(mq_addr), .mq_count(mq_count), .mq_pop(mq_pop),
    .cpl_valid(cpl_valid), .cpl_addr(cpl_addr));

  function automatic logic [15:0] mk(int t, int s, int o);
    logic [9:0] tt = t[9:0];
    logic [1:0] ss = s[1:0];
    logic [3:0] oo = o[3:0];
    return {tt, ss, oo};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reset_to(logic alloc, logic back);
    @(negedge clk);
    rst_n = 1'b0; cfg_alloc_on_write = alloc; cfg_copy_back = back;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acc(logic wr, logic at, logic [15:0] a, int exp, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_atomic = at; req_addr = a;
    #1 chk(tag, resp_status, exp);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_atomic = 1'b0;
  endtask

  task automatic pop_chk(int kind, logic [15:0] a, string tag);
    @(negedge clk); #1;
    chk({tag, " valid"}, mq_valid, 1);
    chk({tag, " kind"}, mq_kind, kind);
    chk({tag, " addr"}, mq_addr, a);
    mq_pop = 1'b1;
    @(posedge clk); #1 mq_pop = 1'b0;
  endtask

  task automatic cnt_chk(int n, string tag);
    @(negedge clk); #1 chk({tag, " count"}, mq_count, n);
  endtask

  task automatic fill(logic [15:0] a);
    @(negedge clk); cpl_valid = 1'b1; cpl_addr = a;
    @(posedge clk); #1 cpl_valid = 1'b0;
  endtask

  task automatic t_reset;
    cnt_chk(0, "R10 reset");
    chk("R10 reset valid", mq_valid, 0);
  endtask

  task automatic t_read_miss_fill;
    acc(0, 0, mk(1,0,5), MISS, "R4 read miss");
    cnt_chk(1, "R4");
    pop_chk(FETCH, mk(1,0,0), "R4 fetch block addr");
    cnt_chk(0, "R10 after pop");
    fill(mk(1,0,0));
    acc(0, 0, mk(1,0,9), HIT, "R11 hit after completion");
    cnt_chk(0, "R2 hit queues nothing");
  endtask

  task automatic t_lru;
    acc(0, 0, mk(1,1,0), MISS, "R2 B1"); pop_chk(FETCH, mk(1,1,0), "R2"); fill(mk(1,1,0));
    acc(0, 0, mk(2,1,0), MISS, "R2 B2"); pop_chk(FETCH, mk(2,1,0), "R2"); fill(mk(2,1,0));
    acc(0, 0, mk(1,1,0), HIT, "R2 B1 hit");
    acc(0, 0, mk(3,1,0), MISS, "R2 B3 miss");
    cnt_chk(1, "R2 clean victim");
    pop_chk(FETCH, mk(3,1,0), "R2"); fill(mk(3,1,0));
    acc(0, 0, mk(1,1,0), HIT, "R2 MRU line kept");
    acc(0, 0, mk(2,1,0), MISS, "R2 LRU line evicted");
    pop_chk(FETCH, mk(2,1,0), "R2"); fill(mk(2,1,0));
  endtask

  task automatic t_atomic;
    acc(0, 0, mk(1,2,0), MISS, "R3 C1"); pop_chk(FETCH, mk(1,2,0), "R3"); fill(mk(1,2,0));
    acc(0, 1, mk(1,2,4), HIT, "R3 atomic hit");
    cnt_chk(0, "R3");
    acc(0, 0, mk(2,2,0), MISS, "R3 C2"); pop_chk(FETCH, mk(2,2,0), "R3"); fill(mk(2,2,0));
    acc(0, 0, mk(3,2,0), MISS, "R3 C3");
    cnt_chk(2, "R6 fetch plus copy-back");
    pop_chk(FETCH, mk(3,2,0), "R6 fetch first");
    pop_chk(CPYBK, mk(1,2,0), "R3 dirty victim copied back");
    fill(mk(3,2,0));
  endtask

  task automatic t_write_back_hit;
    acc(0, 0, mk(1,3,0), MISS, "R9 D1"); pop_chk(FETCH, mk(1,3,0), "R9"); fill(mk(1,3,0));
    acc(1, 0, mk(1,3,4), HIT, "R9 store hit");
    cnt_chk(0, "R9 copy-back store queues nothing");
    acc(0, 0, mk(2,3,0), MISS, "R9 D2"); pop_chk(FETCH, mk(2,3,0), "R9"); fill(mk(2,3,0));
    acc(0, 0, mk(3,3,0), MISS, "R9 D3");
    pop_chk(FETCH, mk(3,3,0), "R9");
    pop_chk(CPYBK, mk(1,3,0), "R9 stored line dirty");
    fill(mk(3,3,0));
  endtask

  task automatic t_write_alloc;
    acc(1, 0, mk(5,0,8), MISS, "R7 store miss");
    cnt_chk(2, "R7");
    pop_chk(STORE, mk(5,0,8), "R7 store first");
    pop_chk(FETCH, mk(5,0,0), "R7 fetch second");
    fill(mk(5,0,0));
    acc(0, 0, mk(5,0,0), HIT, "R7 allocated");
  endtask

  task automatic t_reject_paths;
    acc(0, 0, mk(7,0,0), MISS, "R5 G1");
    acc(0, 0, mk(7,1,0), MISS, "R5 G2");
    cnt_chk(2, "R5");
    acc(1, 0, mk(9,2,0), REJ, "R7 no room for three");
    cnt_chk(2, "R7 reject queues nothing");
    pop_chk(FETCH, mk(7,0,0), "R10 order 1");
    pop_chk(FETCH, mk(7,1,0), "R10 order 2");
    acc(0, 0, mk(9,2,0), REJ, "R5 miss table full");
    acc(0, 0, mk(7,0,4), MISS, "R5 merge");
    cnt_chk(0, "R5 merge queues nothing");
    acc(0, 0, mk(7,0,8), REJ, "R5 merge limit");
    fill(mk(7,0,0)); fill(mk(7,1,0));
    acc(0, 0, mk(9,2,0), MISS, "R11 entry freed");
    pop_chk(FETCH, mk(9,2,0), "R11"); fill(mk(9,2,0));
  endtask

  task automatic t_no_alloc;
    acc(1, 0, mk(1,0,3), MISS, "R8 store miss");
    cnt_chk(1, "R8");
    pop_chk(STORE, mk(1,0,3), "R8 store forwarded");
    acc(0, 0, mk(1,0,0), MISS, "R8 no line allocated");
    pop_chk(FETCH, mk(1,0,0), "R8"); fill(mk(1,0,0));
  endtask

  task automatic t_write_through;
    acc(1, 0, mk(1,0,7), HIT, "R9 write-through hit");
    cnt_chk(1, "R9");
    pop_chk(STORE, mk(1,0,7), "R9 store forwarded");
    acc(0, 1, mk(1,0,0), HIT, "R3 atomic hit");
    acc(0, 0, mk(2,0,0), MISS, "R6"); pop_chk(FETCH, mk(2,0,0), "R6"); fill(mk(2,0,0));
    acc(0, 0, mk(3,0,0), MISS, "R6 dirty victim");
    cnt_chk(1, "R6 no copy-back in write-through");
    pop_chk(FETCH, mk(3,0,0), "R6"); fill(mk(3,0,0));
  endtask

  task automatic t_queue_limits;
    for (int i = 0; i < 3; i++) acc(1, 0, mk(4+i,1,0), MISS, "R8 fill");
    cnt_chk(3, "R8");
    acc(0, 0, mk(8,2,0), REJ, "R4 no room for two");
    acc(1, 0, mk(7,1,0), MISS, "R8 last slot");
    cnt_chk(4, "R8");
    acc(1, 0, mk(8,1,0), REJ, "R8 queue full");
    cnt_chk(4, "R8 reject queues nothing");
    for (int i = 0; i < 4; i++) pop_chk(STORE, mk(4+i,1,0), "R10 FIFO order");
    cnt_chk(0, "R10 drained");
  endtask

  task automatic t_probe_fail;
    acc(0, 0, mk(5,1,0), MISS, "R1 pend 1");
    acc(0, 0, mk(6,1,0), MISS, "R1 pend 2");
    pop_chk(FETCH, mk(5,1,0), "R1"); pop_chk(FETCH, mk(6,1,0), "R1");
    acc(1, 0, mk(7,1,0), REJ, "R1 store to busy set");
    cnt_chk(0, "R1 nothing queued");
    acc(0, 0, mk(9,1,0), REJ, "R1 read to busy set");
    fill(mk(5,1,0)); fill(mk(6,1,0));
    acc(1, 0, mk(7,1,0), MISS, "R1 set free again");
    pop_chk(STORE, mk(7,1,0), "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    reset_to(1'b1, 1'b1);
    t_reset();
    t_read_miss_fill();
    t_lru();
    t_atomic();
    t_write_back_hit();
    t_write_alloc();
    t_reject_paths();
    reset_to(1'b0, 1'b0);
    t_reset();
    t_no_alloc();
    t_write_through();
    t_queue_limits();
    t_probe_fail();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule